// File: doc/BRIEF.md
# Bit-Sliced Ripple ALU with Operand Conditioning

This block is a purely combinational arithmetic/logic unit assembled from identical one-bit slices. Each slice holds four small units: AND, OR, complement-of-B, and a full adder. A two-bit function code goes to a decoder, and the decoder picks exactly one unit for the slice result. The carries pass from slice to slice. The lowest carry-in comes from outside and the highest carry-out is driven to a port.

Three conditioning controls act on the operands before any unit sees them:
- A gate zeroes the A operand.
- An inverter complements the A operand after that gate.
- A second gate zeroes the B operand.

With these controls the one datapath can also produce all-ones, all-zeros, B plus one, B minus one, negation and bitwise complement. The controls apply to every slice at once. The width is a parameter with a default of 8.

Top module: `bitslice_alu`

## Requirements
- R1: With `fsel` = 2'b00 the result is the bitwise AND of the conditioned A and conditioned B operands.
- R2: With `fsel` = 2'b01 the result is the bitwise OR of the conditioned A and conditioned B operands.
- R3: With `fsel` = 2'b10 the result is the bitwise complement of the conditioned B. `opa`, `a_en`, `a_inv` and `cin` have no effect on it.
- R4: With `fsel` = 2'b11, {`cout`, `result`} equals the conditioned A plus the conditioned B plus `cin`, taken as a WIDTH+1-bit sum.
- R5: When `a_en` is 0 and `a_inv` is 0, the conditioned A is all zeros whatever `opa` holds.
- R6: `a_inv` = 1 complements A after gating. So with `a_en` = 0 and `a_inv` = 1 the conditioned A is all ones.
- R7: When `b_en` is 0 the conditioned B is all zeros whatever `opb` holds.
- R8: `cout` is 0 whenever `fsel` is not 2'b11, for any operand or carry-in value.
- R9: Carries ripple through every slice. All-ones plus zero with `cin` = 1 gives a result of 0 and `cout` = 1. 1 + 1 + 0 in a slice gives sum 0 and carry 1.
- R10: For every function code, exactly one of the four decoder select lines is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | WIDTH | A operand |
| opb | input | WIDTH | B operand |
| a_en | input | 1 | 1 passes A; 0 forces A to zero |
| a_inv | input | 1 | Complements the gated A operand |
| b_en | input | 1 | 1 passes B; 0 forces B to zero |
| fsel | input | 2 | Function code: 00 AND, 01 OR, 10 NOT B, 11 ADD |
| cin | input | 1 | Carry into the least significant slice |
| result | output | WIDTH | Selected unit output, one bit per slice |
| cout | output | 1 | Carry out of the most significant slice, 0 unless ADD |

## Verification
Each function is driven with bit patterns chosen to separate it from its neighbours:
- Alternating patterns (0x55/0xAA) tell AND apart from OR and make NOT-B distinct from NOT-A.
- Mixed values such as 0x3C and 0xA5 show which operand reaches the output.

All eight combinations of the three conditioning controls are swept under all four function codes. This separates gating from inversion and shows the order in which they are applied.

The adder is tried at the following boundary values:
- all-ones plus carry-in, to show a full-length ripple;
- zero plus zero;
- the pair 0x80 + 0x80, where only the top carry is set.

The increment, decrement and negation idioms are checked by their arithmetic values. Carry-out is checked to stay low under the non-add codes even when the inputs would carry.

// File: rtl/alu_pkg.sv
package alu_pkg;

   typedef enum logic [1:0] {
      FN_AND  = 2'b00,
      FN_OR   = 2'b01,
      FN_NOTB = 2'b10,
      FN_ADD  = 2'b11
   } alu_fn_e;

   localparam int unsigned FSEL_W = 2;
   localparam int unsigned N_UNITS = 1 << FSEL_W;

endpackage

// File: rtl/alu_fn_decoder.sv
module alu_fn_decoder #(
   parameter int unsigned SEL_W = 2,
   localparam int unsigned N_OUT = 1 << SEL_W
) (
   input  logic [SEL_W-1:0] sel,
   output logic [N_OUT-1:0] lines
);

   if (SEL_W < 1 || SEL_W > 4) begin : g_bad_sel
      $error("alu_fn_decoder: SEL_W out of range");
   end

   logic [N_OUT-1:0] hit;

   for (genvar k = 0; k < N_OUT; k++) begin : g_line
      assign hit[k] = (sel == SEL_W'(k));
   end

   always_comb begin
      lines = hit;
      // R10: one and only one unit enabled per code
      a_r10_one_line: assert ($onehot(lines));
   end

endmodule

// File: rtl/alu_slice.sv
module alu_slice
   import alu_pkg::*;
(
   input  logic               a,
   input  logic               b,
   input  logic               a_en,
   input  logic               a_inv,
   input  logic               b_en,
   input  logic [N_UNITS-1:0] unit_sel,
   input  logic               ci,
   output logic               r,
   output logic               co
);

   logic a_gated, a_eff, b_eff;
   logic u_and, u_or, u_notb, u_sum, u_carry;

   always_comb begin
      a_gated = a & a_en;
      a_eff   = a_gated ^ a_inv;
      b_eff   = b & b_en;

      u_and   = a_eff & b_eff;
      u_or    = a_eff | b_eff;
      u_notb  = ~b_eff;
      u_sum   = a_eff ^ b_eff ^ ci;
      u_carry = (a_eff & b_eff) | (ci & (a_eff ^ b_eff));

      r  = (u_and  & unit_sel[FN_AND])
         | (u_or   & unit_sel[FN_OR])
         | (u_notb & unit_sel[FN_NOTB])
         | (u_sum  & unit_sel[FN_ADD]);
      co = u_carry & unit_sel[FN_ADD];

      // R8: no carry leaves a slice unless the adder is selected
      a_r8_carry_quiet: assert (unit_sel[FN_ADD] || !co);
      // R4: adder slice matches a two-bit arithmetic sum
      a_r4_slice_sum: assert (!unit_sel[FN_ADD] ||
         ({co, r} == (2'({1'b0, a_eff}) + 2'({1'b0, b_eff}) + 2'({1'b0, ci}))));
      // R3: complement unit output depends on B alone
      a_r3_notb_only_b: assert (!unit_sel[FN_NOTB] || (r == !(b && b_en)));
      // R6: enable off plus invert forces the A operand high
      a_r6_forced_one: assert (a_en || !a_inv || a_eff);
   end

endmodule

// File: rtl/bitslice_alu.sv
module bitslice_alu
   import alu_pkg::*;
#(
   parameter int unsigned WIDTH = 8
) (
   input  logic [WIDTH-1:0] opa,
   input  logic [WIDTH-1:0] opb,
   input  logic             a_en,
   input  logic             a_inv,
   input  logic             b_en,
   input  logic [1:0]       fsel,
   input  logic             cin,
   output logic [WIDTH-1:0] result,
   output logic             cout
);

   localparam int unsigned CHAIN_W = WIDTH + 1;

   if (WIDTH < 1 || WIDTH > 1024) begin : g_bad_width
      $error("bitslice_alu: WIDTH out of range");
   end

   logic [N_UNITS-1:0] unit_sel;
   logic [CHAIN_W-1:0] carry;

   alu_fn_decoder #(.SEL_W(FSEL_W)) u_dec (
      .sel   (fsel),
      .lines (unit_sel)
   );

   assign carry[0] = cin;

   for (genvar i = 0; i < WIDTH; i++) begin : g_slice
      alu_slice u_slice (
         .a        (opa[i]),
         .b        (opb[i]),
         .a_en     (a_en),
         .a_inv    (a_inv),
         .b_en     (b_en),
         .unit_sel (unit_sel),
         .ci       (carry[i]),
         .r        (result[i]),
         .co       (carry[i+1])
      );
   end

   assign cout = carry[WIDTH];

endmodule

// File: tb/bitslice_alu_tb.sv
module bitslice_alu_tb;

   localparam int W = 8;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic [W-1:0] opa, opb, result;
   logic a_en, a_inv, b_en, cin, cout;
   logic [1:0] fsel;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   bitslice_alu #(.WIDTH(W)) u_dut (
      .opa(opa), .opb(opb), .a_en(a_en), .a_inv(a_inv), .b_en(b_en),
      .fsel(fsel), .cin(cin), .result(result), .cout(cout)
   );

   function automatic logic [W:0] model(input logic [W-1:0] a, input logic [W-1:0] b,
                                        input logic ea, input logic ia, input logic eb,
                                        input logic [1:0] f, input logic c);
      logic [W-1:0] ca, cb;
      ca = ea ? a : '0;
      if (ia) ca = ~ca;
      cb = eb ? b : '0;
      case (f)
         2'b00:   model = {1'b0, ca & cb};
         2'b01:   model = {1'b0, ca | cb};
         2'b10:   model = {1'b0, ~cb};
         default: model = {1'b0, ca} + {1'b0, cb} + {{W{1'b0}}, c};
      endcase
   endfunction

   task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b, input logic ea,
                        input logic ia, input logic eb, input logic [1:0] f, input logic c);
      @(posedge clk);
      opa = a; opb = b; a_en = ea; a_inv = ia; b_en = eb; fsel = f; cin = c;
      @(negedge clk);
   endtask

   task automatic expect_val(input string req, input logic [W:0] exp);
      checks++;
      if ({cout, result} !== exp) begin
         errors++;
         $display("FAIL %s: got cout=%b result=%h expected cout=%b result=%h",
                  req, cout, result, exp[W], exp[W-1:0]);
      end
   endtask

   task automatic run(input string req, input logic [W-1:0] a, input logic [W-1:0] b,
                      input logic ea, input logic ia, input logic eb, input logic [1:0] f,
                      input logic c);
      drive(a, b, ea, ia, eb, f, c);
      expect_val(req, model(a, b, ea, ia, eb, f, c));
   endtask

   task automatic t_idle;
      drive('0, '0, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0);
      expect_val("R1 idle", '0);
   endtask

   task automatic t_logic;
      run("R1 and", 8'h55, 8'hFF, 1, 0, 1, 2'b00, 1);
      run("R1 and", 8'h3C, 8'hA5, 1, 0, 1, 2'b00, 0);
      run("R2 or",  8'h55, 8'hAA, 1, 0, 1, 2'b01, 1);
      run("R2 or",  8'h3C, 8'h81, 1, 0, 1, 2'b01, 0);
      expect_val("R2 or literal", {1'b0, 8'hBD});
   endtask

   task automatic t_notb;
      run("R3 notb", 8'hFF, 8'hA5, 1, 0, 1, 2'b10, 1);
      expect_val("R3 notb literal", {1'b0, 8'h5A});
      run("R3 notb a ignored", 8'h00, 8'hA5, 0, 1, 1, 2'b10, 0);
      expect_val("R3 notb a ignored literal", {1'b0, 8'h5A});
   endtask

   task automatic t_add;
      run("R4 add", 8'h3C, 8'h0A, 1, 0, 1, 2'b11, 1);
      expect_val("R4 add literal", {1'b0, 8'h47});
      run("R4 dec b", 8'h00, 8'h10, 0, 1, 1, 2'b11, 0);
      expect_val("R4 R6 dec literal", {1'b1, 8'h0F});
      run("R4 neg a", 8'h05, 8'h00, 1, 1, 0, 2'b11, 1);
      expect_val("R4 neg literal", {1'b0, 8'hFB});
   endtask

   task automatic t_conditioning;
      for (int f = 0; f < 4; f++)
         for (int k = 0; k < 8; k++)
            run("R5 R6 R7 sweep", 8'hC6, 8'h5B, k[0], k[1], k[2], f[1:0], f[0]);
      run("R5 a gated", 8'hFF, 8'hFF, 0, 0, 1, 2'b01, 0);
      expect_val("R5 a gated literal", {1'b0, 8'hFF});
      run("R5 a gated and", 8'hFF, 8'hFF, 0, 0, 1, 2'b00, 0);
      expect_val("R5 literal", '0);
      run("R6 forced ones", 8'h00, 8'h00, 0, 1, 0, 2'b01, 0);
      expect_val("R6 literal", {1'b0, 8'hFF});
      run("R7 b gated", 8'h00, 8'hFF, 1, 0, 0, 2'b10, 0);
      expect_val("R7 literal", {1'b0, 8'hFF});
   endtask

   task automatic t_carry;
      run("R9 ripple", 8'hFF, 8'h00, 1, 0, 1, 2'b11, 1);
      expect_val("R9 ripple literal", {1'b1, 8'h00});
      run("R9 top carry", 8'h80, 8'h80, 1, 0, 1, 2'b11, 0);
      expect_val("R9 top literal", {1'b1, 8'h00});
      run("R9 one plus one", 8'h01, 8'h01, 1, 0, 1, 2'b11, 0);
      expect_val("R9 1+1 literal", {1'b0, 8'h02});
      run("R9 zero", 8'h00, 8'h00, 1, 0, 1, 2'b11, 0);
      for (int f = 0; f < 3; f++) begin
         drive(8'hFF, 8'hFF, 1, 0, 1, f[1:0], 1);
         checks++;
         if (cout !== 1'b0) begin
            errors++;
            $display("FAIL R8: cout=%b expected 0 for fsel=%0d", cout, f);
         end
      end
   endtask

   task automatic t_decoder;
      // R10: each code selects a distinct unit; a shared input shows four different outputs
      run("R10 code00", 8'h0F, 8'h33, 1, 0, 1, 2'b00, 0);
      expect_val("R10 and unit", {1'b0, 8'h03});
      run("R10 code01", 8'h0F, 8'h33, 1, 0, 1, 2'b01, 0);
      expect_val("R10 or unit", {1'b0, 8'h3F});
      run("R10 code10", 8'h0F, 8'h33, 1, 0, 1, 2'b10, 0);
      expect_val("R10 notb unit", {1'b0, 8'hCC});
      run("R10 code11", 8'h0F, 8'h33, 1, 0, 1, 2'b11, 0);
      expect_val("R10 add unit", {1'b0, 8'h42});
   endtask

   task automatic summary;
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      t_idle();
      t_logic();
      t_notb();
      t_add();
      t_conditioning();
      t_carry();
      t_decoder();
      done = 1;
      summary();
      $finish;
   end

   initial begin
      #2_000_000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         summary();
         $finish;
      end
   end

endmodule